// File: doc/BRIEF.md
# Bit-Serial Augmented Long-Division CRC

This block computes a CRC remainder one bit per clock by following the long-division definition step for step. Each accepted message bit enters at the low end of an M-bit remainder register while the register shifts left. When the bit pushed out of the top is 1, the generator's low-order taps are XORed into the shifted value. The default is M = 8 with generator x^8 + x^2 + x + 1, whose tap pattern is 0x07.

The caller clears the register, streams the message most-significant bit first, then streams M zero bits. It raises `stream_end` together with the last of those zeros. The remainder on `rem_out` is final once `rem_valid` is high. Because the register starts at zero, it only fills during the first M accepted bits, and no reduction takes place in that stretch. A message of N bits therefore needs N + M accepted cycles.

Top module: `aug_crc_serial`

## Requirements
- R1: Defaults are WIDTH = 8 and TAPS = 8'h07 (generator x^8 + x^2 + x + 1). A single 1 bit followed by eight zeros leaves 8'h07 on `rem_out`.
- R2: On a clock edge where `bit_vld` = 1 and `clear` = 0, the register shifts left by one and takes `bit_in` into bit 0. If the old bit WIDTH-1 was 1, the result is also XORed with TAPS. The new value is on `rem_out` after that edge.
- R3: During the first WIDTH accepted bits after a clear, no reduction occurs. After exactly WIDTH bits, `rem_out` equals those bits, with the first bit in bit WIDTH-1.
- R4: After a message followed by WIDTH zero bits, `rem_out` equals (message · x^WIDTH) mod generator. For 10101010 this is the remainder of 1010101000000000 divided by the generator.
- R5: `clear` = 1 zeroes `rem_out` and `rem_valid` after the edge, and it takes priority over `bit_vld`.
- R6: While `bit_vld` = 0 and `clear` = 0, `rem_out` holds its value.
- R7: `rem_valid` is 1 after an edge where `bit_vld` = 1 and `stream_end` = 1 (with `clear` = 0). It is 0 after an accepted bit with `stream_end` = 0.
- R8: While reset is applied, `rem_out` = 0 and `rem_valid` = 0.
- R9: `stream_end` without `bit_vld` has no effect. `rem_valid` and `rem_out` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clear | input | 1 | Synchronous clear of remainder and valid flag |
| bit_vld | input | 1 | The bit on `bit_in` is accepted this cycle |
| bit_in | input | 1 | Serial message or appended-zero bit, MSB first |
| stream_end | input | 1 | Marks the last appended zero; qualified by `bit_vld` |
| rem_out | output | WIDTH | Current remainder register |
| rem_valid | output | 1 | Remainder is final |

## Verification
Every register update is one edge deep. The effect of an accepted bit, a clear or a `stream_end` shows on `rem_out` and `rem_valid` right after the edge where the input was presented. The bench drives inputs on the falling edge and samples on the next falling edge, so each check reads the result of exactly one rising edge. Internally, reset release takes two extra edges, and the bench waits those out before sending any stimulus. Idle and `stream_end`-only cycles are sampled on the same one-edge schedule, which shows that nothing moved.

// File: rtl/aug_crc_pkg.sv
package aug_crc_pkg;

  localparam int unsigned DEF_WIDTH = 8;
  localparam logic [DEF_WIDTH-1:0] DEF_TAPS = 8'h07;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_SHIFT = 2'd2
  } crc_op_e;

endpackage

// File: rtl/aug_crc_rst_sync.sv
module aug_crc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/aug_crc_shift.sv
module aug_crc_shift
  import aug_crc_pkg::*;
#(
  parameter int unsigned       WIDTH = DEF_WIDTH,
  parameter logic [WIDTH-1:0]  TAPS  = DEF_TAPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  crc_op_e          op,
  input  logic             bit_in,
  output logic [WIDTH-1:0] rem
);
  logic [WIDTH-1:0] rem_q;
  logic [WIDTH-1:0] rem_d;
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] reduced;
  logic             carry_out;

  assign shifted   = {rem_q[WIDTH-2:0], bit_in};
  assign carry_out = rem_q[WIDTH-1];

  // One XOR per tap position; positions whose tap is 0 pass through.
  for (genvar i = 0; i < WIDTH; i++) begin : g_tap
    if (TAPS[i]) begin : g_on
      assign reduced[i] = shifted[i] ^ carry_out;
    end else begin : g_off
      assign reduced[i] = shifted[i];
    end
  end

  always_comb begin
    unique case (op)
      OP_CLEAR: rem_d = '0;
      OP_SHIFT: rem_d = reduced;
      default:  rem_d = rem_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_d;
  end

  assign rem = rem_q;
endmodule

// File: rtl/aug_crc_flag.sv
module aug_crc_flag
  import aug_crc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  crc_op_e op,
  input  logic    stream_end,
  output logic    done
);
  logic done_q;
  logic done_d;

  always_comb begin
    unique case (op)
      OP_CLEAR: done_d = 1'b0;
      OP_SHIFT: done_d = stream_end;
      default:  done_d = done_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign done = done_q;
endmodule

// File: rtl/aug_crc_serial.sv
module aug_crc_serial
  import aug_crc_pkg::*;
#(
  parameter int unsigned      WIDTH = DEF_WIDTH,
  parameter logic [WIDTH-1:0] TAPS  = DEF_TAPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             bit_vld,
  input  logic             bit_in,
  input  logic             stream_end,
  output logic [WIDTH-1:0] rem_out,
  output logic             rem_valid
);
  logic    rst_q_n;
  crc_op_e op;

  aug_crc_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  // Clear wins over a presented bit.
  always_comb begin
    if (clear)        op = OP_CLEAR;
    else if (bit_vld) op = OP_SHIFT;
    else              op = OP_HOLD;
  end

  aug_crc_shift #(.WIDTH(WIDTH), .TAPS(TAPS)) u_shift (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .op     (op),
    .bit_in (bit_in),
    .rem    (rem_out)
  );

  aug_crc_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .op         (op),
    .stream_end (stream_end),
    .done       (rem_valid)
  );
endmodule

// File: rtl/aug_crc_serial_chk.sv
module aug_crc_serial_chk #(
  parameter int unsigned      WIDTH = 8,
  parameter logic [WIDTH-1:0] TAPS  = 8'h07
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             clear,
  input logic             bit_vld,
  input logic             bit_in,
  input logic             stream_end,
  input logic [WIDTH-1:0] rem_out,
  input logic             rem_valid
);
  function automatic logic [WIDTH-1:0] div_step(logic [WIDTH-1:0] r, logic b);
    logic [WIDTH:0] wide;
    wide = {r, b};
    if (wide[WIDTH]) return wide[WIDTH-1:0] ^ TAPS;
    return wide[WIDTH-1:0];
  endfunction

  assert_div_step_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bit_vld && !clear) |=> rem_out == div_step($past(rem_out), $past(bit_in)));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    clear |=> (rem_out == '0) && !rem_valid);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!bit_vld && !clear) |=> $stable(rem_out));

  assert_valid_rise_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bit_vld && stream_end && !clear) |=> rem_valid);

  assert_valid_drop_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bit_vld && !stream_end && !clear) |=> !rem_valid);

  assert_end_ignored_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!bit_vld && !clear) |=> $stable(rem_valid));

  always @(negedge clk) begin
    if (!rst_q_n) begin
      assert_reset_R8: assert (rem_out == '0 && !rem_valid);
    end
  end
endmodule

bind aug_crc_serial aug_crc_serial_chk #(.WIDTH(WIDTH), .TAPS(TAPS)) u_chk (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .clear      (clear),
  .bit_vld    (bit_vld),
  .bit_in     (bit_in),
  .stream_end (stream_end),
  .rem_out    (rem_out),
  .rem_valid  (rem_valid)
);

// File: tb/aug_crc_serial_test.sv
module aug_crc_serial_test;
  logic       clk;
  logic       rst_n;
  logic       clear;
  logic       bit_vld;
  logic       bit_in;
  logic       stream_end;
  logic [7:0] rem_out;
  logic       rem_valid;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  aug_crc_serial uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .bit_vld    (bit_vld),
    .bit_in     (bit_in),
    .stream_end (stream_end),
    .rem_out    (rem_out),
    .rem_valid  (rem_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Plain long division over GF(2), top bit downward.
  function automatic logic [7:0] ref_rem(logic [31:0] v, int n);
    for (int i = n - 1; i >= 8; i--) begin
      if (v[i]) v = v ^ (32'h107 << (i - 8));
    end
    return v[7:0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic v, logic b, logic e, logic c);
    bit_vld = v; bit_in = b; stream_end = e; clear = c;
    @(negedge clk);
    bit_vld = 0; bit_in = 0; stream_end = 0; clear = 0;
  endtask

  task automatic feed(logic [31:0] msg, int n, int gap);
    for (int i = n - 1; i >= 0; i--) begin
      logic [7:0] snap;
      step(1'b1, msg[i], 1'b0, 1'b0);
      snap = rem_out;
      for (int g = 0; g < gap; g++) begin
        step(1'b0, 1'b0, 1'b0, 1'b0);
        chk("R6 hold while idle", rem_out, snap);
      end
    end
  endtask

  task automatic zeros_and_end();
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, i == 7, 1'b0);
  endtask

  initial begin
    rst_n = 1; clear = 0; bit_vld = 0; bit_in = 0; stream_end = 0;
    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R8 reset rem", rem_out, 0);
    chk("R8 reset valid", rem_valid, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: single one bit plus eight zeros gives the tap pattern
    step(1'b0, 1'b0, 1'b0, 1'b1);
    feed(32'h1, 1, 0);
    zeros_and_end();
    chk("R1 tap pattern", rem_out, 8'h07);

    // R4: the alternating example
    step(1'b0, 1'b0, 1'b0, 1'b1);
    feed(32'hAA, 8, 0);
    zeros_and_end();
    chk("R4 example 10101010", rem_out, ref_rem(32'hAA00, 16));

    // Exhaustive sweep over all 8-bit messages (R3, R4, R7)
    for (int m = 0; m < 256; m++) begin
      step(1'b0, 1'b0, 1'b0, 1'b1);
      feed(32'(m), 8, 0);
      chk("R3 fill without reduction", rem_out, 32'(m));
      chk("R7 valid low mid-stream", rem_valid, 0);
      zeros_and_end();
      chk("R4 sweep remainder", rem_out, ref_rem(32'(m) << 8, 16));
      chk("R7 valid after end", rem_valid, 1);
    end

    // R2/R6: 16-bit messages with idle gaps between bits
    for (int k = 0; k < 6; k++) begin
      logic [31:0] msg;
      msg = 32'(16'hC3A5 ^ (k * 16'h1357));
      step(1'b0, 1'b0, 1'b0, 1'b1);
      feed(msg, 16, k % 3);
      zeros_and_end();
      chk("R2 16-bit remainder", rem_out, ref_rem(msg << 8, 24));
    end

    // R9: stream_end alone changes nothing
    step(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R9 valid kept", rem_valid, 1);
    chk("R9 rem kept", rem_out, ref_rem(32'(16'hC3A5 ^ (5 * 16'h1357)) << 8, 24));
    // R7: next accepted bit without end drops valid
    step(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R7 valid dropped", rem_valid, 0);

    // R5: clear has priority over a presented bit
    step(1'b1, 1'b1, 1'b1, 1'b1);
    chk("R5 clear rem", rem_out, 0);
    chk("R5 clear valid", rem_valid, 0);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    chk("R9 end alone after clear", rem_valid, 0);

    // R8: reset mid-stream
    feed(32'h5B, 8, 0);
    rst_n = 0;
    @(negedge clk);
    chk("R8 mid-stream reset rem", rem_out, 0);
    chk("R8 mid-stream reset valid", rem_valid, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule